// File: doc/BRIEF.md
# Clock Domain Source Selector and Phase Divider

This block generates one domain clock from a set of candidate source clocks. A single 32-bit control word chooses the source, sets how many source periods the output spends high and how many it spends low, and can bypass the divider so that the chosen source passes straight through. The block runs on a fast reference clock. Each source is brought in through its own synchronizer, and all decisions are taken on the rising edges seen there. The output therefore only changes on reference-clock edges.

Software changes the source by writing a new select code. The block then parks the output low at the end of the current period, moves to the new source, lets that source run for a few settle edges, and restarts the output on a full period. A status bit stays set for the whole handover. New wait and hold counts are staged and take effect only after an explicit update request. Hardware clears the request when the counts are loaded, which happens at the end of an output period.

A strap parameter ties a domain to a fixed source. A second parameter narrows the counts, which gives the memory-style variant with ratios of 2 to 16.

Top module: `domain_clkgen`

## Requirements
- R1: Select field bits [2:0] choose the source: 0 = slow real-time clock, 1 = main oscillator, 2, 3 and 4 = the three PLL inputs (srcClk bit index equals the code). The output is derived only from the selected source.
- R2: A write of select code 5, 6 or 7 is rejected. The select field keeps its previous value and the output keeps running from the previous source.
- R3: Bit 3 is read-only. It reads 1 from the write that changes the source until the handover completes, then returns to 0.
- R4: A source change is glitch-free. The output is held low from the end of an old-source period until the new source has given SETTLE_TICKS rising edges. No high pulse during the change is shorter than the shorter high time of the old and new settings.
- R5: With bypass clear, the output is high for wait+1 and low for hold+1 periods of the selected source. Wait is in bits [19:16] and hold in bits [23:20], so the ratio is wait+hold+2 and an odd ratio puts the extra period in the low phase.
- R6: With bit 24 set, the output follows the selected source level.
- R7: Staged wait/hold values have no effect until a write with bit 25 set. Bit 25 reads 1 until hardware loads the values at the end of an output period, then reads 0. Writing 0 to bit 25 does not cancel a pending request.
- R8: With CNT_W=4 the ratio spans 2 to 32. With CNT_W=3 the upper count bits are dropped and read as 0, which limits the ratio to 16.
- R9: With FIXED_SRC set, select writes are ignored, the field always reads 4, and the output is derived from source 4.
- R10: After reset the word reads 0x0100_0001: oscillator selected, bypass on, counts 0, both status bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, faster than every source |
| rstN | input | 1 | Active-low synchronous reset |
| srcClk | input | NUM_SRC | Candidate source clocks, asynchronous to clk |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Control word and status readback |
| domainClk | output | 1 | Generated domain clock |

## Verification
If the switch state machine is stuck, bit 3 stays set and the output stays low from the first period boundary after a select write. Both are visible within one output period. A wrong phase counter or a lost staged value changes the measured high or low time of the very next full period after the update request clears. Because the cleared request bit marks the exact load boundary, a mismatch shows within two output periods. A wrong register mask shows at once in the readback of the select and count fields.

// File: rtl/dmnclk_pkg.sv
package dmnclk_pkg;
  localparam int SEL_W      = 3;
  localparam int FIELD_W    = 4;
  localparam int BUSY_BIT   = 3;
  localparam int WAIT_LSB   = 16;
  localparam int HOLD_LSB   = 20;
  localparam int BYPASS_BIT = 24;
  localparam int UPDATE_BIT = 25;

  typedef enum logic [1:0] {SW_IDLE, SW_DRAIN, SW_SETTLE} swState_t;

  // control -> datapath
  typedef struct packed {
    logic               stopReq;
    logic [SEL_W-1:0]   activeSel;
    logic               bypass;
    logic               loadReq;
    logic [FIELD_W-1:0] waitCfg;
    logic [FIELD_W-1:0] holdCfg;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic halted;
    logic selRise;
    logic loaded;
  } dpStatus_t;
endpackage

// File: rtl/domain_clkgen_ctl.sv
module domain_clkgen_ctl
  import dmnclk_pkg::*;
#(
  parameter int NUM_SRC      = 5,
  parameter int CNT_W        = 4,
  parameter int FIXED_SRC    = 0,
  parameter int FIXED_CODE   = 4,
  parameter int SETTLE_TICKS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  dpStatus_t   dpStat,
  output ctlStrobes_t ctlBus
);
  localparam logic [SEL_W-1:0]   RESET_SEL = (FIXED_SRC != 0) ? SEL_W'(FIXED_CODE) : SEL_W'(1);
  localparam logic [FIELD_W-1:0] CNT_MASK  = FIELD_W'((1 << CNT_W) - 1);
  localparam int                 SC_W      = $clog2(SETTLE_TICKS + 1);
  localparam logic [SC_W-1:0]    SC_LAST   = SC_W'(SETTLE_TICKS - 1);

  logic [SEL_W-1:0]   selReq, activeSel;
  logic [FIELD_W-1:0] waitR, holdR;
  logic               bypassR, updPend, busy;
  logic [SC_W-1:0]    settleCnt;
  swState_t           swState;
  logic               unusedWr;

  assign unusedWr = ^{wrData[31:26], wrData[15:3]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReq    <= RESET_SEL;
      activeSel <= RESET_SEL;
      waitR     <= '0;
      holdR     <= '0;
      bypassR   <= 1'b1;
      updPend   <= 1'b0;
      settleCnt <= '0;
      swState   <= SW_IDLE;
    end else begin
      if (dpStat.loaded) updPend <= 1'b0;
      if (wrEn) begin
        if (FIXED_SRC == 0 && int'(wrData[SEL_W-1:0]) < NUM_SRC)
          selReq <= wrData[SEL_W-1:0];
        waitR   <= wrData[WAIT_LSB +: FIELD_W] & CNT_MASK;
        holdR   <= wrData[HOLD_LSB +: FIELD_W] & CNT_MASK;
        bypassR <= wrData[BYPASS_BIT];
        if (wrData[UPDATE_BIT]) updPend <= 1'b1;
      end
      unique case (swState)
        SW_IDLE:  if (selReq != activeSel) swState <= SW_DRAIN;
        SW_DRAIN: if (dpStat.halted) begin
          activeSel <= selReq;
          settleCnt <= '0;
          swState   <= SW_SETTLE;
        end
        SW_SETTLE: if (dpStat.selRise) begin
          if (settleCnt == SC_LAST) swState <= SW_IDLE;
          else settleCnt <= settleCnt + 1'b1;
        end
        default: swState <= SW_IDLE;
      endcase
    end
  end

  assign busy = (swState != SW_IDLE) || (selReq != activeSel);

  always_comb begin
    ctlBus.stopReq   = (swState != SW_IDLE);
    ctlBus.activeSel = activeSel;
    ctlBus.bypass    = bypassR;
    ctlBus.loadReq   = updPend;
    ctlBus.waitCfg   = waitR;
    ctlBus.holdCfg   = holdR;
  end

  always_comb begin
    rdData                         = '0;
    rdData[SEL_W-1:0]              = selReq;
    rdData[BUSY_BIT]               = busy;
    rdData[WAIT_LSB +: FIELD_W]    = waitR;
    rdData[HOLD_LSB +: FIELD_W]    = holdR;
    rdData[BYPASS_BIT]             = bypassR;
    rdData[UPDATE_BIT]             = updPend;
  end
endmodule

// File: rtl/domain_clkgen_dp.sv
module domain_clkgen_dp
  import dmnclk_pkg::*;
#(
  parameter int NUM_SRC     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcClk,
  input  ctlStrobes_t        ctlBus,
  output dpStatus_t          dpStat,
  output logic               domainClk
);
  logic [SYNC_STAGES-1:0] syncQ [NUM_SRC];
  logic [NUM_SRC-1:0]     lvl, prevLvl;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ[g]   <= '0;
        prevLvl[g] <= 1'b0;
      end else begin
        syncQ[g]   <= {syncQ[g][SYNC_STAGES-2:0], srcClk[g]};
        prevLvl[g] <= syncQ[g][SYNC_STAGES-1];
      end
    end
    assign lvl[g] = syncQ[g][SYNC_STAGES-1];
  end

  logic               selLvl, selRise, phaseHigh, halted;
  logic [FIELD_W-1:0] cnt, waitAct, holdAct;
  logic               atBoundary, startNow, haltNow;

  assign selLvl  = lvl[ctlBus.activeSel];
  assign selRise = selLvl & ~prevLvl[ctlBus.activeSel];

  always_comb begin
    atBoundary = ctlBus.bypass || (!phaseHigh && cnt == holdAct);
    startNow   = 1'b0;
    haltNow    = 1'b0;
    if (halted) begin
      startNow = !ctlBus.stopReq && !ctlBus.bypass && selRise;
    end else if (ctlBus.stopReq) begin
      haltNow = ctlBus.bypass ? !selLvl : (selRise && atBoundary);
    end else begin
      startNow = selRise && atBoundary;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseHigh <= 1'b0;
      halted    <= 1'b0;
      cnt       <= '0;
      waitAct   <= '0;
      holdAct   <= '0;
    end else if (haltNow) begin
      halted    <= 1'b1;
      phaseHigh <= 1'b0;
      cnt       <= '0;
    end else if (halted && !ctlBus.stopReq && ctlBus.bypass && !selLvl) begin
      halted <= 1'b0;
    end else if (startNow) begin
      halted    <= 1'b0;
      phaseHigh <= 1'b1;
      cnt       <= '0;
      if (ctlBus.loadReq) begin
        waitAct <= ctlBus.waitCfg;
        holdAct <= ctlBus.holdCfg;
      end
    end else if (!halted && selRise) begin
      if (phaseHigh && cnt == waitAct) begin
        phaseHigh <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dpStat.halted  = halted;
  assign dpStat.selRise = selRise;
  assign dpStat.loaded  = startNow && ctlBus.loadReq;

  assign domainClk = halted ? 1'b0 : (ctlBus.bypass ? selLvl : phaseHigh);
endmodule

// File: rtl/domain_clkgen.sv
module domain_clkgen
  import dmnclk_pkg::*;
#(
  parameter int NUM_SRC      = 5,
  parameter int CNT_W        = 4,
  parameter int FIXED_SRC    = 0,
  parameter int FIXED_CODE   = 4,
  parameter int SETTLE_TICKS = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               domainClk
);
  ctlStrobes_t ctlBus;
  dpStatus_t   dpStat;

  domain_clkgen_ctl #(
    .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .FIXED_SRC(FIXED_SRC),
    .FIXED_CODE(FIXED_CODE), .SETTLE_TICKS(SETTLE_TICKS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .dpStat(dpStat), .ctlBus(ctlBus)
  );

  domain_clkgen_dp #(
    .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .ctlBus(ctlBus),
    .dpStat(dpStat), .domainClk(domainClk)
  );
endmodule

// File: rtl/domain_clkgen_chk.sv
module domain_clkgen_chk #(
  parameter int NUM_SRC    = 5,
  parameter int FIXED_SRC  = 0,
  parameter int FIXED_CODE = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] rdData,
  input logic        domainClk,
  input logic        stopReq,
  input logic        halted,
  input logic        loaded,
  input logic        bypassOn
);
  // R2: select field never holds an illegal code
  p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(rdData[2:0]) < NUM_SRC);

  // R9: strapped domain always reads the fixed code
  p_fixed_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (FIXED_SRC != 0) |-> (int'(rdData[2:0]) == FIXED_CODE));

  // R4: a parked datapath never drives the output high
  p_parked_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !domainClk);

  // R3: the handover is always reported as busy
  p_busy_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> rdData[3]);

  // R7: a load in divide mode starts a high phase
  p_load_boundary_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loaded && !bypassOn && !stopReq) |=> domainClk);

  // R7: pending request persists until loaded
  p_upd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[25] && !loaded && !wrEn) |=> rdData[25]);
endmodule

bind domain_clkgen domain_clkgen_chk #(
  .NUM_SRC(NUM_SRC), .FIXED_SRC(FIXED_SRC), .FIXED_CODE(FIXED_CODE)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdData(rdData),
  .domainClk(domainClk), .stopReq(ctlBus.stopReq),
  .halted(dpStat.halted), .loaded(dpStat.loaded), .bypassOn(ctlBus.bypass)
);

// File: tb/domain_clkgen_tb.sv
module domain_clkgen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0, s4 = 1'b0;
  logic [4:0]  srcClk;
  logic        wrEn = 1'b0, fWrEn = 1'b0;
  logic [31:0] wrData = '0, fWrData = '0;
  logic [31:0] rdData, fRdData;
  logic        domainClk, fClk;
  int errors = 0, checks = 0;

  // half periods in clk cycles: rtc 10, osc 3, pll1 2, pll2 5, pll3 4
  assign srcClk = {s4, s3, s2, s1, s0};
  always #10 clk = ~clk;
  initial begin #5; forever #200 s0 = ~s0; end
  initial begin #5; forever #60  s1 = ~s1; end
  initial begin #5; forever #40  s2 = ~s2; end
  initial begin #5; forever #100 s3 = ~s3; end
  initial begin #5; forever #80  s4 = ~s4; end

  domain_clkgen u_dut (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .domainClk(domainClk));

  domain_clkgen #(.CNT_W(3), .FIXED_SRC(1)) u_fix (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .wrEn(fWrEn),
    .wrData(fWrData), .rdData(fRdData), .domainClk(fClk));

  // high-run monitor for the glitch check
  logic monClr = 1'b1;
  int   runLen = 0, minHigh = 999;
  always @(negedge clk) begin
    if (monClr) begin runLen = 0; minHigh = 999; end
    else if (domainClk) runLen++;
    else begin
      if (runLen > 0 && runLen < minHigh) minHigh = runLen;
      runLen = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input bit useFix, input logic [31:0] d);
    @(negedge clk);
    if (useFix) begin fWrEn = 1'b1; fWrData = d; end
    else begin wrEn = 1'b1; wrData = d; end
    @(negedge clk);
    wrEn = 1'b0; fWrEn = 1'b0;
  endtask

  function automatic logic probe(input bit useFix);
    return useFix ? fClk : domainClk;
  endfunction

  task automatic measure(input bit useFix, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (probe(useFix) && guard < 5000) begin @(negedge clk); guard++; end
    while (!probe(useFix) && guard < 5000) begin @(negedge clk); guard++; end
    while (probe(useFix) && guard < 5000) begin hi++; @(negedge clk); guard++; end
    while (!probe(useFix) && guard < 5000) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R10 reset word", int'(rdData), 32'h0100_0001);
    check("R9 strapped reset word", int'(fRdData), 32'h0100_0004);
  endtask

  task automatic testBypass();
    int hi, lo;
    measure(1'b0, hi, lo);
    check("R6 bypass high", hi, 3);
    check("R6 bypass low", lo, 3);
  endtask

  task automatic testDivide();
    int hi, lo;
    regWrite(1'b0, (32'd1 << 25) | (32'd4 << 20) | (32'd2 << 16) | 32'd1);
    check("R7 request pending", int'(rdData[25]), 1);
    repeat (200) @(negedge clk);
    check("R7 request cleared", int'(rdData[25]), 0);
    measure(1'b0, hi, lo);
    check("R5 high wait=2", hi, 18);
    check("R5 low hold=4", lo, 30);
  endtask

  task automatic testNoUpdate();
    int hi, lo;
    regWrite(1'b0, (32'd5 << 20) | (32'd5 << 16) | 32'd1);
    repeat (200) @(negedge clk);
    check("R7 staged fields read back", int'(rdData[23:16]), 8'h55);
    measure(1'b0, hi, lo);
    check("R7 staged high ignored", hi, 18);
    check("R7 staged low ignored", lo, 30);
  endtask

  task automatic testOddRatio();
    int hi, lo;
    regWrite(1'b0, (32'd1 << 25) | (32'd3 << 20) | (32'd2 << 16) | 32'd1);
    repeat (300) @(negedge clk);
    measure(1'b0, hi, lo);
    check("R5 odd ratio high", hi, 18);
    check("R5 odd ratio low", lo, 24);
  endtask

  task automatic testMaxRatio();
    int hi, lo;
    regWrite(1'b0, (32'd1 << 25) | (32'd15 << 20) | (32'd15 << 16) | 32'd1);
    repeat (600) @(negedge clk);
    measure(1'b0, hi, lo);
    check("R8 ratio 32 high", hi, 96);
    check("R8 ratio 32 low", lo, 96);
  endtask

  task automatic testSwitch();
    int hi, lo, guard;
    regWrite(1'b0, (32'd1 << 24) | 32'd1);
    repeat (50) @(negedge clk);
    monClr = 1'b0;
    regWrite(1'b0, (32'd1 << 24) | 32'd2);
    check("R3 busy set", int'(rdData[3]), 1);
    guard = 0;
    while (rdData[3] && guard < 500) begin @(negedge clk); guard++; end
    check("R3 busy cleared", int'(rdData[3]), 0);
    repeat (20) @(negedge clk);
    check("R4 saw pulses", int'(minHigh != 999), 1);
    check("R4 no short pulse", int'(minHigh >= 2), 1);
    monClr = 1'b1;
    measure(1'b0, hi, lo);
    check("R1 code 2 high", hi, 2);
    check("R1 code 2 low", lo, 2);
    regWrite(1'b0, (32'd1 << 24) | 32'd3);
    repeat (100) @(negedge clk);
    check("R3 busy after code 3", int'(rdData[3]), 0);
    measure(1'b0, hi, lo);
    check("R1 code 3 high", hi, 5);
  endtask

  task automatic testIllegal();
    int hi, lo;
    regWrite(1'b0, (32'd1 << 24) | 32'd7);
    check("R2 field kept", int'(rdData[2:0]), 3);
    repeat (50) @(negedge clk);
    check("R2 no switch", int'(rdData[3]), 0);
    measure(1'b0, hi, lo);
    check("R2 old source kept", hi, 5);
  endtask

  task automatic testFixed();
    int hi, lo;
    regWrite(1'b1, (32'd1 << 25) | (32'd15 << 20) | (32'd15 << 16) | 32'd1);
    check("R9 select reads 4", int'(fRdData[2:0]), 4);
    check("R8 narrow wait", int'(fRdData[19:16]), 7);
    check("R8 narrow hold", int'(fRdData[23:20]), 7);
    repeat (400) @(negedge clk);
    measure(1'b1, hi, lo);
    check("R8 R9 ratio 16 high", hi, 64);
    check("R8 R9 ratio 16 low", lo, 64);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testBypass();
    testDivide();
    testNoUpdate();
    testOddRatio();
    testMaxRatio();
    testSwitch();
    testIllegal();
    testFixed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule